// File: doc/BRIEF.md
# Read-After-Write Stall Interlock

This block guards a five-stage in-order pipeline that has no bypass network. The register file is written in writeback and read in decode, three stages apart, so an instruction sitting in decode may need a value that an older instruction in execute, memory or writeback has not yet written. The interlock compares the decode instruction's two source register numbers against the destination numbers of those three stages. A match freezes the fetch PC and the decode latch, and sends a bubble into execute in place of the held instruction.

The surrounding pipeline tells the block which sources the decode instruction actually reads: ALU, load, store, branch and register-jump instructions read one or both sources, while a plain jump reads none. It also tells the block which of the three downstream stages holds a register writer: only ALU/immediate instructions and loads write. A bubble enters execute with its write flag clear, so it never causes a stall of its own. Register 0 always reads as zero and is never a hazard. A free-running count of stall cycles is also provided. Over a program of N instructions with S stall cycles, average CPI is (N+S)/N.

Top module: `raw_interlock`

## Requirements
- R1: When `id_use_a` is high and `id_src_a` is nonzero, `ex_flush` is high in the same cycle if `id_src_a` equals the destination of any of the execute, memory or writeback stages whose write flag is high.
- R2: The same rule applies to the second source: `id_use_b` and `id_src_b` are checked against the same three stages.
- R3: A source whose use flag is low never causes a stall, even when its number matches a pending destination.
- R4: A downstream stage whose write flag is low never causes a stall, even when its destination matches a source in use.
- R5: A source number of 0 never causes a stall.
- R6: `pc_en` and `ifid_en` are both low exactly when `ex_flush` is high, and both are high otherwise.
- R7: With no qualifying match in any of the six source/stage pairs, `ex_flush` is low.
- R8: `stall_cycles` is 0 after reset. On every rising clock edge it increases by one if `ex_flush` was high and holds otherwise, wrapping modulo 2^CNT_W.
- R9: In a closed-loop pipeline that inserts write-cleared bubbles on a stall, a consumer at distance d (1 to 3) behind its producer stalls for exactly 4-d cycles. At distance 4 or more it does not stall.

Ports table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the stall counter |
| id_src_a | input | REG_AW | First source register of the decode instruction |
| id_src_b | input | REG_AW | Second source register of the decode instruction |
| id_use_a | input | 1 | Decode instruction reads its first source |
| id_use_b | input | 1 | Decode instruction reads its second source |
| ex_dst | input | REG_AW | Destination register in execute |
| ex_wr | input | 1 | Execute instruction writes a register |
| mem_dst | input | REG_AW | Destination register in memory |
| mem_wr | input | 1 | Memory instruction writes a register |
| wb_dst | input | REG_AW | Destination register in writeback |
| wb_wr | input | 1 | Writeback instruction writes a register |
| pc_en | output | 1 | Fetch PC may advance |
| ifid_en | output | 1 | Decode instruction latch may load |
| ex_flush | output | 1 | Insert a bubble into execute this cycle |
| stall_cycles | output | CNT_W | Count of stall cycles since reset |

## Verification
The hardest case to reach is the stall length over time. It depends on the block's own bubbles moving down the pipeline and on the producer leaving writeback, and no single combination of port values shows it. The bench closes the loop with a small behavioural model of the execute, memory and writeback registers. The model advances every cycle, loads a write-cleared bubble whenever `ex_flush` is high, and holds the decode instruction while the stall lasts. It runs a producer followed by a consumer at distances 1 through 4, and compares both the stall cycles it observes and the counter's change against 4-d.

// File: rtl/raw_interlock.sv
module raw_interlock #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_use_a,
  input  logic              id_use_b,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr,
  output logic              pc_en,
  output logic              ifid_en,
  output logic              ex_flush,
  output logic [CNT_W-1:0]  stall_cycles
);

  logic live_a, live_b, hit_a, hit_b, stall;

  assign live_a = id_use_a && (id_src_a != '0);
  assign live_b = id_use_b && (id_src_b != '0);

  assign hit_a = live_a && ((ex_wr  && ex_dst  == id_src_a) ||
                            (mem_wr && mem_dst == id_src_a) ||
                            (wb_wr  && wb_dst  == id_src_a));

  assign hit_b = live_b && ((ex_wr  && ex_dst  == id_src_b) ||
                            (mem_wr && mem_dst == id_src_b) ||
                            (wb_wr  && wb_dst  == id_src_b));

  assign stall    = hit_a || hit_b;
  assign pc_en    = !stall;
  assign ifid_en  = !stall;
  assign ex_flush = stall;

  always_ff @(posedge clk) begin
    if (!rst_n)
      stall_cycles <= '0;
    else if (stall)
      stall_cycles <= stall_cycles + 1'b1;
  end

endmodule

// File: rtl/raw_interlock_chk.sv
module raw_interlock_chk #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] id_src_a,
  input logic [REG_AW-1:0] id_src_b,
  input logic              id_use_a,
  input logic              id_use_b,
  input logic              ex_wr,
  input logic              mem_wr,
  input logic              wb_wr,
  input logic              pc_en,
  input logic              ifid_en,
  input logic              ex_flush,
  input logic [CNT_W-1:0]  stall_cycles
);

  // R6
  freeze_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ex_flush |-> (!pc_en && !ifid_en));

  // R6
  run_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_flush |-> (pc_en && ifid_en));

  // R3
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_use_a && !id_use_b) |-> !ex_flush);

  // R4
  no_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wr && !mem_wr && !wb_wr) |-> !ex_flush);

  // R5
  zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0 && id_src_b == '0) |-> !ex_flush);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |=> stall_cycles == $past(stall_cycles) + CNT_W'($past(ex_flush)));

endmodule

bind raw_interlock raw_interlock_chk #(.REG_AW(REG_AW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .id_src_a(id_src_a), .id_src_b(id_src_b),
  .id_use_a(id_use_a), .id_use_b(id_use_b), .ex_wr(ex_wr), .mem_wr(mem_wr),
  .wb_wr(wb_wr), .pc_en(pc_en), .ifid_en(ifid_en), .ex_flush(ex_flush),
  .stall_cycles(stall_cycles)
);

// File: tb/sim_raw_interlock.sv
`timescale 1ns/1ps
module sim_raw_interlock;
  localparam int AW = 5;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] src_a = '0, src_b = '0, exd = '0, memd = '0, wbd = '0;
  logic use_a = 1'b0, use_b = 1'b0, exw = 1'b0, memw = 1'b0, wbw = 1'b0;
  logic pc_en, ifid_en, ex_flush;
  logic [CW-1:0] scnt;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  raw_interlock #(.REG_AW(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .id_src_a(src_a), .id_src_b(src_b),
    .id_use_a(use_a), .id_use_b(use_b), .ex_dst(exd), .ex_wr(exw),
    .mem_dst(memd), .mem_wr(memw), .wb_dst(wbd), .wb_wr(wbw),
    .pc_en(pc_en), .ifid_en(ifid_en), .ex_flush(ex_flush), .stall_cycles(scnt)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic idle();
    src_a = '0; src_b = '0; use_a = 0; use_b = 0;
    exd = '0; memd = '0; wbd = '0; exw = 0; memw = 0; wbw = 0;
  endtask

  task automatic set_stage(input int st, input logic [AW-1:0] d, input logic w);
    exw = 0; memw = 0; wbw = 0; exd = 7; memd = 7; wbd = 7;
    case (st)
      0: begin exd = d; exw = w; end
      1: begin memd = d; memw = w; end
      default: begin wbd = d; wbw = w; end
    endcase
  endtask

  task automatic look(input string req, input logic exp_stall);
    #1;
    chk(req, ex_flush, exp_stall);
    chk({req, " pc_en"}, pc_en, !exp_stall);
    chk({req, " ifid_en"}, ifid_en, !exp_stall);
  endtask

  task automatic t_reset();
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk("R8 reset count", scnt, 0);
    look("R7 idle", 1'b0);
  endtask

  task automatic t_src_a();
    for (int st = 0; st < 3; st++) begin
      @(negedge clk); idle();
      src_a = 9; use_a = 1; src_b = 4; use_b = 1;
      set_stage(st, 9, 1'b1);
      look("R1 src_a hit", 1'b1);
    end
  endtask

  task automatic t_src_b();
    for (int st = 0; st < 3; st++) begin
      @(negedge clk); idle();
      src_a = 3; use_a = 1; src_b = 21; use_b = 1;
      set_stage(st, 21, 1'b1);
      look("R2 src_b hit", 1'b1);
    end
  endtask

  task automatic t_use_gate();
    @(negedge clk); idle();
    src_a = 12; use_a = 0; src_b = 13; use_b = 1;
    set_stage(0, 12, 1'b1);
    look("R3 use_a low", 1'b0);
    @(negedge clk);
    src_a = 13; use_a = 1; src_b = 12; use_b = 0;
    set_stage(2, 12, 1'b1);
    look("R3 use_b low", 1'b0);
  endtask

  task automatic t_wr_gate();
    for (int st = 0; st < 3; st++) begin
      @(negedge clk); idle();
      src_a = 17; use_a = 1; src_b = 17; use_b = 1;
      set_stage(st, 17, 1'b0);
      look("R4 write flag low", 1'b0);
    end
  endtask

  task automatic t_zero();
    @(negedge clk); idle();
    use_a = 1; use_b = 1;
    exd = 0; exw = 1; memd = 0; memw = 1; wbd = 0; wbw = 1;
    look("R5 reg zero", 1'b0);
  endtask

  task automatic t_clear();
    @(negedge clk); idle();
    src_a = 1; src_b = 2; use_a = 1; use_b = 1;
    exd = 3; exw = 1; memd = 4; memw = 1; wbd = 5; wbw = 1;
    look("R7 no match", 1'b0);
  endtask

  task automatic t_counter();
    int base;
    @(negedge clk); idle();
    base = scnt;
    src_a = 8; use_a = 1; exd = 8; exw = 1;
    repeat (5) @(posedge clk);
    @(negedge clk); idle();
    chk("R8 count after 5 stalls", scnt - base, 5);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 count holds", scnt - base, 5);
  endtask

  task automatic t_pipe(input int d);
    logic [AW-1:0] p_src [0:15];
    logic [AW-1:0] p_dst [0:15];
    logic          p_use [0:15];
    logic          p_wr  [0:15];
    logic [AW-1:0] m_exd, m_memd, m_wbd;
    logic          m_exw, m_memw, m_wbw;
    int pc, seen, base;
    for (int i = 0; i < 16; i++) begin
      p_src[i] = 0; p_dst[i] = 0; p_use[i] = 0; p_wr[i] = 0;
    end
    p_dst[0] = 6; p_wr[0] = 1;
    for (int k = 1; k < d; k++) begin
      p_dst[k] = AW'(10 + k); p_wr[k] = 1; p_src[k] = 1; p_use[k] = 1;
    end
    p_src[d] = 6; p_use[d] = 1;
    m_exw = 0; m_memw = 0; m_wbw = 0; m_exd = 0; m_memd = 0; m_wbd = 0;
    pc = 0; seen = 0;
    @(negedge clk); idle();
    base = scnt;
    for (int cyc = 0; cyc < 20; cyc++) begin
      src_a = p_src[pc]; use_a = p_use[pc]; src_b = 0; use_b = 0;
      exd = m_exd; exw = m_exw; memd = m_memd; memw = m_memw; wbd = m_wbd; wbw = m_wbw;
      @(negedge clk);
      if (ex_flush) seen++;
      m_wbd = m_memd; m_wbw = m_memw;
      m_memd = m_exd; m_memw = m_exw;
      if (ex_flush) begin
        m_exd = 0; m_exw = 0;
      end else begin
        m_exd = p_dst[pc]; m_exw = p_wr[pc];
        if (pc < 15) pc++;
      end
    end
    idle();
    chk($sformatf("R9 stalls at distance %0d", d), seen, (d < 4) ? 4 - d : 0);
    chk($sformatf("R9 counter at distance %0d", d), scnt - base, (d < 4) ? 4 - d : 0);
  endtask

  initial begin
    t_reset();
    t_src_a();
    t_src_b();
    t_use_gate();
    t_wr_gate();
    t_zero();
    t_clear();
    t_counter();
    for (int d = 1; d <= 4; d++) t_pipe(d);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule